// File: doc/BRIEF.md
# Receive Idle Time-out Detector

This block sits beside a serial receiver's data FIFO and tells the interrupt logic when received characters have been left unread for too long. It counts serial bit periods, marked by a one-cycle tick from the baud generator, during which no new character arrives. The count runs only while the FIFO holds data. When the count reaches the threshold (32 bit periods by default), a sticky time-out flag is raised.

The flag drops when the FIFO empties or when software writes the time-out clear strobe. A parameter selects single-location mode, in which the FIFO is a lone holding register. In that mode any read of it also counts as draining. Every received character restarts the silence count. An explicit clear while data remains also restarts it, so the flag returns only after a further full window of silence.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `timeout_o` is 0.
- R2: While `fifo_empty` is 1 at a clock edge, `timeout_o` is 0 after that edge. The silence count is also held at zero, so ticks seen while the FIFO is empty do not advance it.
- R3: With the FIFO not empty, `timeout_o` rises at the clock edge that samples the THRESH-th `bit_tick` (default 32) counted since the count last restarted. It stays 0 after THRESH-1 such ticks.
- R4: A cycle with `rx_char` = 1 restarts the silence count at zero, and this takes priority over a `bit_tick` in the same cycle. The flag cannot rise at that edge.
- R5: While the FIFO is empty, any number of ticks leaves the flag at 0. After the FIFO becomes non-empty, a full THRESH ticks are still needed.
- R6: A cycle with `to_clr` = 1 forces `timeout_o` to 0 and restarts the count. The flag re-asserts only after THRESH further silent ticks.
- R7: Once set, the flag stays at 1 for any number of further ticks. The count saturates at THRESH and does not wrap.
- R8: With ONE_DEEP = 1, a cycle with `fifo_rd` = 1 clears the flag and restarts the count. With ONE_DEEP = 0, a read while `fifo_empty` stays 0 changes neither the flag nor the count.
- R9: A character that arrives while the flag is set does not clear the flag. Only draining or `to_clr` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| rx_char | input | 1 | One-cycle pulse per character written into the FIFO |
| fifo_empty | input | 1 | Receive FIFO empty status |
| fifo_rd | input | 1 | One-cycle pulse per FIFO read |
| to_clr | input | 1 | Software clear of the time-out flag |
| timeout_o | output | 1 | Sticky receive time-out flag |

## Verification
Only the silence count and the flag hold state in this block, so any wrong internal value appears at `timeout_o` within at most THRESH ticks. A count that is too high, or that fails to restart, raises the flag early. One that is too low, or that is held, raises it late. A missed clear shows on the very next clock. The bench runs a behavioural model alongside both parameter variants and compares the flag every cycle. It then adds directed checks at the tick before and at the tick of each expected rise.

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int THRESH   = 32,
  parameter bit ONE_DEEP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_char,
  input  logic fifo_empty,
  input  logic fifo_rd,
  input  logic to_clr,
  output logic timeout_o
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);
  localparam logic [CW-1:0] TOP  = CW'(THRESH);

  logic [CW-1:0] cnt;
  logic          flag;

  wire drain   = fifo_empty | (ONE_DEEP & fifo_rd);
  wire restart = drain | to_clr | rx_char;
  wire hit     = bit_tick & ~restart & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart)                 cnt <= '0;
    else if (bit_tick && cnt != TOP)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               flag <= 1'b0;
    else if (drain || to_clr) flag <= 1'b0;
    else if (hit)             flag <= 1'b1;
  end

  assign timeout_o = flag;
endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk #(
  parameter bit ONE_DEEP = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic rx_char,
  input logic fifo_empty,
  input logic fifo_rd,
  input logic to_clr,
  input logic timeout_o
);
  a_r2_empty_drops: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> !timeout_o);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    to_clr |=> !timeout_o);

  a_r4_char_blocks_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char && !timeout_o) |=> !timeout_o);

  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(bit_tick));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !fifo_empty && !to_clr && !(ONE_DEEP && fifo_rd)) |=> timeout_o);

  a_r8_single_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ONE_DEEP && fifo_rd) |=> !timeout_o);
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.ONE_DEEP(ONE_DEEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_char(rx_char),
  .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .to_clr(to_clr),
  .timeout_o(timeout_o)
);

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb;
  localparam int TH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, rx_char = 1'b0, fifo_empty = 1'b1, fifo_rd = 1'b0, to_clr = 1'b0;
  logic f0, f1;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_idle_timeout #(.THRESH(TH), .ONE_DEEP(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_char(rx_char),
    .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .to_clr(to_clr), .timeout_o(f0));

  rx_idle_timeout #(.THRESH(TH), .ONE_DEEP(1'b1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_char(rx_char),
    .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .to_clr(to_clr), .timeout_o(f1));

  int quiet [2];
  bit mflag [2];

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        quiet[m] <= 0; mflag[m] <= 1'b0;
      end else if (fifo_empty || (m == 1 && fifo_rd) || to_clr) begin
        quiet[m] <= 0; mflag[m] <= 1'b0;
      end else if (rx_char) begin
        quiet[m] <= 0;
      end else if (bit_tick) begin
        if (quiet[m] + 1 >= TH) mflag[m] <= 1'b1;
        quiet[m] <= (quiet[m] + 1 > TH) ? TH : quiet[m] + 1;
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(f0, mflag[0], "R3 R6 model compare, single-buffer mode off");
      check(f1, mflag[1], "R8 model compare, single-buffer mode on");
    end
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input logic t, input logic c, input logic e, input logic r, input logic k);
    bit_tick = t; rx_char = c; fifo_empty = e; fifo_rd = r; to_clr = k;
    @(negedge clk);
    bit_tick = 1'b0; rx_char = 1'b0; fifo_rd = 1'b0; to_clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, fifo_empty, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, fifo_empty, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, fifo_empty, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(f0, 1'b0, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(f0, 1'b0, "R1 after reset release");

    fifo_empty = 1'b1;
    ticks(40);
    check(f0, 1'b0, "R5 ticks while empty");
    fifo_empty = 1'b0;
    ticks(TH - 1);
    check(f0, 1'b0, "R5 one tick short after becoming non-empty");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check(f0, 1'b1, "R3 rise on the threshold tick");

    ticks(50);
    check(f0, 1'b1, "R7 saturated, still set");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(f0, 1'b1, "R9 character keeps flag");

    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check(f0, 1'b0, "R6 clear drops flag");
    ticks(TH - 1);
    check(f0, 1'b0, "R6 no early re-assert");
    ticks(1);
    check(f0, 1'b1, "R6 re-assert after full window");

    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    ticks(20);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    ticks(TH - 1);
    check(f0, 1'b0, "R4 character restarts count");
    ticks(1);
    check(f0, 1'b1, "R4 rise a full window after character");

    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    ticks(TH - 1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check(f0, 1'b0, "R4 character beats simultaneous tick");
    ticks(TH - 1);
    check(f0, 1'b0, "R4 window restarted by character");
    ticks(1);
    check(f0, 1'b1, "R4 rise after restarted window");

    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check(f0, 1'b0, "R2 empty drops flag");
    fifo_empty = 1'b0;
    ticks(TH - 1);
    check(f0, 1'b0, "R2 count was held at zero");
    ticks(1);
    check(f0, 1'b1, "R3 rise after refill");
    check(f1, 1'b1, "R8 single-buffer variant also set");

    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(f0, 1'b1, "R8 read with data left, mode off");
    check(f1, 1'b0, "R8 read clears in single-buffer mode");
    ticks(TH - 1);
    check(f1, 1'b0, "R8 count restarted by read");
    ticks(1);
    check(f1, 1'b1, "R8 re-assert after read");
    check(f0, 1'b1, "R7 mode-off flag unchanged");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule